// File: doc/BRIEF.md
# Debug Bus-Match Trigger Unit

This unit watches a CPU bus and decides when a debug trigger and a CPU break request should fire. The bus carries an address, separate write and read data buses, a direction line (1 = read), an opcode-fetch strobe and an execute strobe. Two programmable comparators, A and B, are combined by a selectable mode into one trigger condition. A third comparator, C, acts as a standalone breakpoint that requests a break but never raises the trigger pulse.

Triggering is either immediate (a qualified bus match fires in the same cycle) or deferred. In deferred mode every opcode fetch enters a small in-order queue that stands in for the CPU pipeline. A fetch whose address matches carries a tag, and the tag fires only when that instruction reaches the execute strobe. A flush input discards all queued fetches, which models a change of flow. Triggering requires the unit to be armed. Firing disarms it and sets a sticky status bit, and only a new arm clears that bit.

Top module: `dbg_match_trigger`

## Requirements
- R1: With a comparator's direction check disabled, an address match qualifies on both reads and writes, and no data compare takes place.
- R2: With the direction check enabled and the direction bit 0, only writes (`bus_read`=0) qualify. When comparator A's data compare is enabled, `bus_wdata` must also equal `a_data`.
- R3: With the direction check enabled and the direction bit 1, only reads (`bus_read`=1) qualify. When comparator A's data compare is enabled, `bus_rdata` must also equal `a_data`.
- R4: In immediate mode (`tag_mode`=0), `trig_pulse` is high combinationally in the cycle of the qualifying bus access. It is one cycle wide, even when the match is held.
- R5: In deferred mode (`tag_mode`=1), direction checks are ignored and only opcode fetches are tagged. The tag fires `trig_pulse` in the cycle in which `bus_exec` retires that fetch from a first-in first-out queue of 4 fetches. A matching non-fetch access never fires.
- R6: `mode` encodes 0 = A alone, 1 = A or B, 2 = A and B, 3 = A and not B. The combination is evaluated on the same bus cycle, and the encoding applies in both trigger kinds.
- R7: In modes 2 and 3, comparator B is qualified with A's direction-check and direction bits, and its own bits are ignored.
- R8: When a retired fetch carries both a C tag and an A/B tag, only the C breakpoint fires; `trig_pulse` stays low and `status_triggered` stays clear.
- R9: `flush` empties the fetch queue; tags fetched before it never fire. A fetch or retire in the flush cycle is discarded.
- R10: `arm` sets `status_armed` and clears `status_triggered`. A trigger fires only while armed, and firing clears `status_armed` and sets `status_triggered` on the next clock.
- R11: `brk_req` rises on the clock after a trigger or a C fire. C fires on any access to `c_addr` when `c_on_exec`=0, or when a C-tagged fetch retires when it is 1. `brk_req` holds until `brk_ack`; a new fire in the acknowledge cycle wins.
- R12: During reset `trig_pulse`, `brk_req`, `status_armed` and `status_triggered` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm the unit, clearing the triggered status |
| mode | input | 2 | A/B combination mode |
| tag_mode | input | 1 | 0 immediate trigger, 1 deferred (tagged) trigger |
| a_addr | input | AW | Comparator A address |
| a_data | input | DW | Comparator A data value |
| a_data_chk | input | 1 | Enable data compare on A |
| a_dir_chk | input | 1 | Enable direction check on A |
| a_dir_rd | input | 1 | A direction: 1 read, 0 write |
| b_addr | input | AW | Comparator B address |
| b_dir_chk | input | 1 | Enable direction check on B |
| b_dir_rd | input | 1 | B direction: 1 read, 0 write |
| c_addr | input | AW | Breakpoint C address |
| c_enable | input | 1 | Enable breakpoint C |
| c_on_exec | input | 1 | C deferred to execution (1) or immediate (0) |
| bus_valid | input | 1 | Bus cycle present |
| bus_addr | input | AW | Bus address |
| bus_read | input | 1 | Bus direction, 1 read |
| bus_wdata | input | DW | Write data bus |
| bus_rdata | input | DW | Read data bus |
| bus_fetch | input | 1 | Bus cycle is an opcode fetch |
| bus_exec | input | 1 | Oldest fetched instruction executes |
| flush | input | 1 | Discard all queued fetches |
| brk_ack | input | 1 | CPU acknowledges the break |
| trig_pulse | output | 1 | One-cycle trigger |
| brk_req | output | 1 | Held break request |
| status_armed | output | 1 | Unit is armed |
| status_triggered | output | 1 | Sticky triggered flag |

## Verification
The assertions watch properties that hold on every cycle: the pulse stays one cycle wide, a trigger needs the armed state and leaves the triggered status behind, a deferred trigger never fires outside an execute strobe, a C-tagged retire never raises the trigger, a flush leaves the queue empty, and a break request holds until acknowledged. Only the bench scenarios can show the value-level outcomes: which direction and data settings qualify a match, how each mode combines A and B, which queued fetch a retire fires and in what order, and that a non-fetch access never tags.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [1:0] {
    MODE_A_ONLY  = 2'd0,
    MODE_A_OR_B  = 2'd1,
    MODE_A_AND_B = 2'd2,
    MODE_A_NOT_B = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic hit_ab;
    logic hit_c;
  } tag_ent_t;

  // direction qualification of one comparator
  function automatic logic dir_ok(input logic chk, input logic want_rd, input logic is_rd);
    return !chk || (is_rd == want_rd);
  endfunction

  // A/B combination per mode
  function automatic logic combine(input trig_mode_e md, input logic ha, input logic hb);
    logic r;
    case (md)
      MODE_A_ONLY:  r = ha;
      MODE_A_OR_B:  r = ha || hb;
      MODE_A_AND_B: r = ha && hb;
      default:      r = ha && !hb;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dbg_cmp.sv
module dbg_cmp #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_read,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic [AW-1:0] cmp_addr,
  input  logic [DW-1:0] cmp_data,
  input  logic          data_chk,
  input  logic          dir_chk,
  input  logic          dir_rd,
  output logic          addr_hit,
  output logic          qual_hit
);
  import dbg_trig_pkg::*;

  logic data_ok;

  assign addr_hit = (bus_addr == cmp_addr);

  generate
    if (HAS_DATA) begin : g_data
      // data compare only when the direction is fixed; the bus follows the direction
      assign data_ok = !(dir_chk && data_chk) ||
                       ((dir_rd ? bus_rdata : bus_wdata) == cmp_data);
    end else begin : g_nodata
      logic unused_data;
      assign unused_data = ^{bus_wdata, bus_rdata, cmp_data, data_chk};
      assign data_ok = 1'b1;
    end
  endgenerate

  assign qual_hit = addr_hit && dir_ok(dir_chk, dir_rd, bus_read) && data_ok;

endmodule

// File: rtl/dbg_tag_fifo.sv
module dbg_tag_fifo #(
  parameter int DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    push,
  input  dbg_trig_pkg::tag_ent_t  push_ent,
  input  logic                    pop,
  output dbg_trig_pkg::tag_ent_t  head,
  output logic                    empty
);
  import dbg_trig_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  tag_ent_t        mem [DEPTH];
  logic [PW-1:0]   rd_q, wr_q;
  logic [CW-1:0]   cnt_q;
  logic            do_pop, do_push;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);
  assign head    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (!flush && do_push) mem[wr_q] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/dbg_match_trigger.sv
module dbg_match_trigger #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int TAG_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [1:0]    mode,
  input  logic          tag_mode,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_data,
  input  logic          a_data_chk,
  input  logic          a_dir_chk,
  input  logic          a_dir_rd,
  input  logic [AW-1:0] b_addr,
  input  logic          b_dir_chk,
  input  logic          b_dir_rd,
  input  logic [AW-1:0] c_addr,
  input  logic          c_enable,
  input  logic          c_on_exec,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_read,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_fetch,
  input  logic          bus_exec,
  input  logic          flush,
  input  logic          brk_ack,
  output logic          trig_pulse,
  output logic          brk_req,
  output logic          status_armed,
  output logic          status_triggered
);
  import dbg_trig_pkg::*;

  trig_mode_e mode_e;
  logic       full_mode, b_chk_eff, b_rd_eff;
  logic       a_addr_hit, a_qual, b_addr_hit, b_qual, c_addr_hit, c_qual;
  logic       ev_force_ab, ev_ab_tag_fire, ev_c_tag_fire, ev_c_force, c_fire;
  logic       exec_take, fifo_empty, fetch_push;
  tag_ent_t   tag_new, tag_head;
  logic       armed_q, trig_q, brk_q;

  assign mode_e    = trig_mode_e'(mode);
  assign full_mode = (mode_e == MODE_A_AND_B) || (mode_e == MODE_A_NOT_B);
  // full modes: B borrows A's direction qualification
  assign b_chk_eff = full_mode ? a_dir_chk : b_dir_chk;
  assign b_rd_eff  = full_mode ? a_dir_rd  : b_dir_rd;

  dbg_cmp #(.AW(AW), .DW(DW), .HAS_DATA(1'b1)) u_cmp_a (
    .bus_addr(bus_addr), .bus_read(bus_read), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_addr(a_addr), .cmp_data(a_data), .data_chk(a_data_chk),
    .dir_chk(a_dir_chk), .dir_rd(a_dir_rd), .addr_hit(a_addr_hit), .qual_hit(a_qual));

  dbg_cmp #(.AW(AW), .DW(DW), .HAS_DATA(1'b0)) u_cmp_b (
    .bus_addr(bus_addr), .bus_read(bus_read), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_addr(b_addr), .cmp_data('0), .data_chk(1'b0),
    .dir_chk(b_chk_eff), .dir_rd(b_rd_eff), .addr_hit(b_addr_hit), .qual_hit(b_qual));

  dbg_cmp #(.AW(AW), .DW(DW), .HAS_DATA(1'b0)) u_cmp_c (
    .bus_addr(bus_addr), .bus_read(bus_read), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_addr(c_addr), .cmp_data('0), .data_chk(1'b0),
    .dir_chk(1'b0), .dir_rd(1'b0), .addr_hit(c_addr_hit), .qual_hit(c_qual));

  // immediate A/B event
  assign ev_force_ab = bus_valid && !tag_mode && combine(mode_e, a_qual, b_qual);

  // fetch tagging: direction settings ignored
  assign fetch_push     = bus_valid && bus_fetch;
  assign tag_new.hit_ab = tag_mode && combine(mode_e, a_addr_hit, b_addr_hit);
  assign tag_new.hit_c  = c_enable && c_on_exec && c_addr_hit;

  dbg_tag_fifo #(.DEPTH(TAG_DEPTH)) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(fetch_push), .push_ent(tag_new),
    .pop(bus_exec), .head(tag_head), .empty(fifo_empty));

  assign exec_take      = bus_exec && !fifo_empty && !flush;
  assign ev_c_tag_fire  = exec_take && tag_head.hit_c;
  assign ev_ab_tag_fire = exec_take && tag_head.hit_ab && !tag_head.hit_c;
  assign ev_c_force     = bus_valid && c_enable && !c_on_exec && c_qual;
  assign c_fire         = ev_c_tag_fire || ev_c_force;

  assign trig_pulse = armed_q && (ev_force_ab || ev_ab_tag_fire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else if (arm) begin
      armed_q <= 1'b1;
      trig_q  <= 1'b0;
    end else if (trig_pulse) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      brk_q <= 1'b0;
    else if (trig_pulse || c_fire)   brk_q <= 1'b1;
    else if (brk_ack)                brk_q <= 1'b0;
  end

  assign brk_req          = brk_q;
  assign status_armed     = armed_q;
  assign status_triggered = trig_q;

endmodule

// File: rtl/dbg_match_trigger_chk.sv
module dbg_match_trigger_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic tag_mode,
  input logic bus_exec,
  input logic flush,
  input logic brk_ack,
  input logic trig_pulse,
  input logic brk_req,
  input logic status_armed,
  input logic status_triggered,
  input logic c_fire,
  input logic ev_c_tag_fire,
  input logic fifo_empty
);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && !arm) |=> !trig_pulse);

  assert_needs_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> status_armed);

  assert_sticky_after_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && !arm) |=> (status_triggered && !status_armed));

  assert_deferred_on_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_mode && !bus_exec) |-> !trig_pulse);

  assert_c_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_c_tag_fire && tag_mode) |-> !trig_pulse);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fifo_empty);

  assert_brk_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse || c_fire) |=> brk_req);

  assert_brk_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !brk_ack) |=> brk_req);

endmodule

bind dbg_match_trigger dbg_match_trigger_chk u_chk (.*);

// File: tb/test_dbg_match_trigger.sv
module test_dbg_match_trigger;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  md;
    logic        achk, ard, bchk, brd;
    logic [15:0] baddr, addr;
    logic        rd, exp;
    logic [3:0]  req;
  } vec_t;

  // A address is 0x1000 throughout the table; immediate mode
  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2000, 16'h1000, 1'b1, 1'b1, 4'd1},  // R1 read
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2000, 16'h1000, 1'b0, 1'b1, 4'd1},  // R1 write
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h2000, 16'h1000, 1'b0, 1'b1, 4'd2},  // R2 write ok
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h2000, 16'h1000, 1'b1, 1'b0, 4'd2},  // R2 read rejected
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h2000, 16'h1000, 1'b1, 1'b1, 4'd3},  // R3 read ok
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h2000, 16'h1000, 1'b0, 1'b0, 4'd3},  // R3 write rejected
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2000, 16'h1004, 1'b1, 1'b0, 4'd6},  // R6 miss
    '{2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h2000, 16'h2000, 1'b0, 1'b0, 4'd6},  // R6 OR, B own check
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2000, 16'h2000, 1'b0, 1'b1, 4'd6},  // R6 OR via B
    '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 16'h1000, 16'h1000, 1'b1, 1'b1, 4'd7},  // R7 B uses A dir
    '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 16'h1000, 16'h1000, 1'b0, 1'b0, 4'd7},  // R7 write rejected
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1000, 16'h1000, 1'b1, 1'b0, 4'd6},  // R6 A and not B
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'h2000, 16'h1000, 1'b1, 1'b1, 4'd6}   // R6 A and not B
  };

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
  logic [1:0] mode = 2'd0;
  logic tag_mode = 1'b0;
  logic [15:0] a_addr = 16'h1000, a_data = 16'h0000, b_addr = 16'h2000, c_addr = 16'h3000;
  logic a_data_chk = 1'b0, a_dir_chk = 1'b0, a_dir_rd = 1'b0, b_dir_chk = 1'b0, b_dir_rd = 1'b0;
  logic c_enable = 1'b0, c_on_exec = 1'b0;
  logic bus_valid = 1'b0, bus_read = 1'b0, bus_fetch = 1'b0, bus_exec = 1'b0, flush = 1'b0;
  logic [15:0] bus_addr = 16'h0000, bus_wdata = 16'h0000, bus_rdata = 16'h0000;
  logic brk_ack = 1'b0;
  logic trig_pulse, brk_req, status_armed, status_triggered;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_match_trigger i_dbg_match_trigger (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .tag_mode(tag_mode),
    .a_addr(a_addr), .a_data(a_data), .a_data_chk(a_data_chk), .a_dir_chk(a_dir_chk),
    .a_dir_rd(a_dir_rd), .b_addr(b_addr), .b_dir_chk(b_dir_chk), .b_dir_rd(b_dir_rd),
    .c_addr(c_addr), .c_enable(c_enable), .c_on_exec(c_on_exec),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_read(bus_read),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_fetch(bus_fetch),
    .bus_exec(bus_exec), .flush(flush), .brk_ack(brk_ack),
    .trig_pulse(trig_pulse), .brk_req(brk_req),
    .status_armed(status_armed), .status_triggered(status_triggered));

  task automatic check(input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic nclk();
    @(negedge clk);
  endtask

  task automatic do_arm();
    arm = 1'b1; nclk(); arm = 1'b0;
  endtask

  task automatic bus_idle();
    bus_valid = 1'b0; bus_fetch = 1'b0; bus_exec = 1'b0; flush = 1'b0;
  endtask

  task automatic fetch(input logic [15:0] ad);
    bus_valid = 1'b1; bus_fetch = 1'b1; bus_read = 1'b1; bus_addr = ad; bus_exec = 1'b0;
  endtask

  task automatic retire();
    bus_valid = 1'b0; bus_fetch = 1'b0; bus_exec = 1'b1;
  endtask

  task automatic ack();
    brk_ack = 1'b1; nclk(); brk_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // R12 reset state
    repeat (3) nclk();
    #1;
    check("R12 trig in reset", trig_pulse, 1'b0);
    check("R12 brk in reset", brk_req, 1'b0);
    check("R12 armed in reset", status_armed, 1'b0);
    check("R12 triggered in reset", status_triggered, 1'b0);
    rst_n = 1'b1;
    nclk();

    // table of immediate-mode vectors
    for (int i = 0; i < NV; i++) begin
      mode = TBL[i].md; a_dir_chk = TBL[i].achk; a_dir_rd = TBL[i].ard;
      b_dir_chk = TBL[i].bchk; b_dir_rd = TBL[i].brd; b_addr = TBL[i].baddr;
      do_arm();
      bus_valid = 1'b1; bus_addr = TBL[i].addr; bus_read = TBL[i].rd;
      #2;
      check($sformatf("R%0d vec %0d trig", TBL[i].req, i), trig_pulse, TBL[i].exp);
      nclk(); bus_idle();
      #1;
      check($sformatf("R%0d vec %0d status", TBL[i].req, i), status_triggered, TBL[i].exp);
      check($sformatf("R11 vec %0d brk", i), brk_req, TBL[i].exp);
      ack();
    end
    mode = 2'd0; b_addr = 16'h2000; b_dir_chk = 1'b0; b_dir_rd = 1'b0;

    // R2 data compare on write bus
    a_dir_chk = 1'b1; a_dir_rd = 1'b0; a_data_chk = 1'b1; a_data = 16'h0055;
    do_arm();
    bus_valid = 1'b1; bus_addr = 16'h1000; bus_read = 1'b0; bus_wdata = 16'h0055; bus_rdata = 16'h00AA;
    #2; check("R2 write data match", trig_pulse, 1'b1);
    nclk(); bus_idle(); ack();
    do_arm();
    bus_valid = 1'b1; bus_wdata = 16'h00AA; bus_rdata = 16'h0055;
    #2; check("R2 write data mismatch", trig_pulse, 1'b0);
    nclk(); bus_idle();
    // R3 data compare on read bus
    a_dir_rd = 1'b1; do_arm();
    bus_valid = 1'b1; bus_read = 1'b1;
    #2; check("R3 read data match", trig_pulse, 1'b1);
    nclk(); bus_idle(); ack();
    a_data_chk = 1'b0; a_dir_chk = 1'b0; a_dir_rd = 1'b0;

    // R4 single pulse while match held; R10 disarm and sticky
    do_arm();
    bus_valid = 1'b1; bus_addr = 16'h1000; bus_read = 1'b1;
    #2; check("R4 first cycle", trig_pulse, 1'b1);
    nclk(); #2;
    check("R4 held match no second pulse", trig_pulse, 1'b0);
    check("R10 disarmed", status_armed, 1'b0);
    check("R10 triggered set", status_triggered, 1'b1);
    nclk(); bus_idle();
    // R11 break holds until acknowledge
    repeat (3) nclk();
    #1; check("R11 brk held", brk_req, 1'b1);
    ack(); #1; check("R11 brk cleared", brk_req, 1'b0);
    // R10 re-arm clears sticky bit
    do_arm(); #1;
    check("R10 rearm armed", status_armed, 1'b1);
    check("R10 rearm clears triggered", status_triggered, 1'b0);

    // R5 deferred: direction settings ignored, fires on retire
    tag_mode = 1'b1; a_dir_chk = 1'b1; a_dir_rd = 1'b0;
    fetch(16'h1000); #2; check("R5 no fire at fetch", trig_pulse, 1'b0);
    nclk(); fetch(16'h1002);
    nclk(); bus_idle(); retire(); #2; check("R5 fire at retire", trig_pulse, 1'b1);
    nclk(); #2; check("R5 untagged retire", trig_pulse, 1'b0);
    nclk(); bus_idle(); ack();
    a_dir_chk = 1'b0;

    // R5 queue order, 4 deep
    do_arm();
    fetch(16'h1002); nclk(); fetch(16'h1004); nclk(); fetch(16'h1000); nclk(); fetch(16'h1006); nclk();
    bus_idle(); retire(); #2; check("R5 order 1", trig_pulse, 1'b0);
    nclk(); #2; check("R5 order 2", trig_pulse, 1'b0);
    nclk(); #2; check("R5 order 3 tagged", trig_pulse, 1'b1);
    nclk(); #2; check("R5 order 4", trig_pulse, 1'b0);
    nclk(); bus_idle(); ack();

    // R5 non-fetch access never tags
    do_arm();
    bus_valid = 1'b1; bus_fetch = 1'b0; bus_read = 1'b1; bus_addr = 16'h1000;
    #2; check("R5 data read no fire", trig_pulse, 1'b0);
    nclk(); fetch(16'h1002);
    nclk(); bus_idle(); retire(); #2; check("R5 non-opcode retire 1", trig_pulse, 1'b0);
    nclk(); #2; check("R5 non-opcode retire 2", trig_pulse, 1'b0);
    nclk(); bus_idle(); #1; check("R5 still armed", status_armed, 1'b1);

    // R9 flush drops a pending tag
    fetch(16'h1000); nclk();
    bus_idle(); flush = 1'b1; nclk();
    flush = 1'b0; retire(); #2; check("R9 flushed tag", trig_pulse, 1'b0);
    nclk(); bus_idle(); #1; check("R9 not triggered", status_triggered, 1'b0);

    // R8 C tag on same fetch wins
    c_addr = 16'h1000; c_enable = 1'b1; c_on_exec = 1'b1;
    fetch(16'h1000); #2; check("R8 no fire at fetch", trig_pulse, 1'b0);
    nclk(); bus_idle(); #1; check("R11 no brk before retire", brk_req, 1'b0);
    retire(); #2; check("R8 trigger suppressed", trig_pulse, 1'b0);
    nclk(); bus_idle(); #1;
    check("R8 C break raised", brk_req, 1'b1);
    check("R8 triggered stays clear", status_triggered, 1'b0);
    ack();

    // R11 immediate C breakpoint, and set wins over acknowledge
    tag_mode = 1'b0; c_on_exec = 1'b0; c_addr = 16'h3000;
    bus_valid = 1'b1; bus_addr = 16'h3000; bus_read = 1'b1;
    #2; check("R11 C never pulses trigger", trig_pulse, 1'b0);
    nclk(); bus_idle(); #1; check("R11 C immediate brk", brk_req, 1'b1);
    bus_valid = 1'b1; brk_ack = 1'b1;
    nclk(); bus_idle(); brk_ack = 1'b0; #1;
    check("R11 set wins over ack", brk_req, 1'b1);
    ack(); #1; check("R11 ack clears", brk_req, 1'b0);

    nclk();
    report();
  end

endmodule